// File: doc/BRIEF.md
# Oversampling Serial Receiver with Break Handling

This block turns an asynchronous serial line into stored characters. The line is first passed through a two-flop synchronizer. It is then observed on every pulse of a 16x oversampling enable. A falling edge arms the receiver, which confirms the start bit a fixed number of ticks later. It then samples 5 to 8 data bits, an optional parity bit and one stop bit, each at the centre of its bit time. Each finished character goes into a small receive queue, and its parity error, framing error and break flags go with it. The flags of the oldest entry therefore appear together with that entry's data.

Two line conditions get special treatment. The first is a character with a bad stop bit whose data is not zero. If the line is still low half a bit after the stop sample, that moment is taken as the start edge of the next character. The second is a break, where the line stays low through the whole frame including the stop bit. A break is stored as a zero character with its break flag set. The receiver then waits until the synchronized line has been high on two consecutive clock edges before it looks for a start edge again.

A consumer polls `rx_rdy`, reads the head entry on `rd_data` and its flag outputs, and pops it with `rd_en`. A character that arrives while the queue is full is dropped and raises a sticky overrun flag, which `err_clr` clears.

Top module: `rx_deframer`

## Requirements
- R1: A start is armed by a high-to-low change of the synchronized line seen on a tick. The line is sampled again CONFIRM ticks later (default 8). If it is high then, the start is rejected, nothing is stored, and edge search resumes.
- R2: Data bits are taken every 16 ticks after the start confirmation, least significant bit first. The count is 5 + `cfg_len` (`cfg_len`=0 gives 5 bits, 3 gives 8 bits).
- R3: For characters shorter than 8 bits, the stored bits above the character length read as zero.
- R4: With `cfg_par_en`=1, one parity bit follows the data. `cfg_par_odd`=0 expects an even count of ones over data plus parity, and 1 expects an odd count. A mismatch sets the entry's parity flag.
- R5: A high stop bit stores the character with all flags clear, and the receiver accepts a start edge immediately afterwards, so back-to-back frames with no idle time are received.
- R6: A low stop bit on a character that is not a break sets the entry's framing flag and stores the assembled data.
- R7: After a framing error on a non-zero character, if the line is low 8 ticks after the stop sample, that tick counts as a start edge and the next character is received without any high-to-low transition.
- R8: A line low through data, parity and stop stores data 0x00 with the break flag set and the parity and framing flags clear.
- R9: After a break, no new character is started until the synchronized line is high on two consecutive clock edges. A high lasting a single clock does not end the break.
- R10: The queue returns entries in arrival order with their own flags. `rx_rdy` is high exactly while the queue holds an entry. `rd_en` with the queue empty has no effect.
- R11: A character that completes while the queue is full is discarded and `ovr_err` is set. The flag stays set until `err_clr` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| rxd | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| rd_en | input | 1 | Pop the head entry |
| err_clr | input | 1 | Clear the overrun flag |
| rx_rdy | output | 1 | Queue holds at least one entry |
| rd_data | output | 8 | Head entry data |
| rd_par_err | output | 1 | Head entry parity flag |
| rd_frm_err | output | 1 | Head entry framing flag |
| rd_brk | output | 1 | Head entry break flag |
| ovr_err | output | 1 | Sticky overrun flag |

## Verification
A wrong bit counter or tick phase shows up as a corrupted or shifted `rd_data` on the very frame where it occurs, so it is visible as soon as that entry reaches the head. A receiver that misses the restart after a framing error, or leaves a break state too early, does its damage one frame later: the next character is lost or garbled, or an extra zero/break entry appears. The bench therefore always inspects the frame that follows each special line condition. Faults in queue pointers or counts show up when `rx_rdy` rises or falls, or when entries come out of order, on the pop that follows the fault.

// File: rtl/rx_pkg.sv
package rx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_HALF,
        S_BRK
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       par_err;
        logic       frm_err;
        logic       brk;
    } rx_entry_t;

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import rx_pkg::*;
#(
    parameter int OSR     = 16,
    parameter int CONFIRM = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rxd,
    input  logic [1:0] cfg_len,
    input  logic      par_en,
    input  logic      par_odd,
    output logic      push,
    output rx_entry_t wr_entry
);
    localparam int CW   = $clog2(OSR);
    localparam int HALF = OSR / 2;

    typedef struct packed {
        rx_state_e      st;
        logic [CW-1:0]  cnt;
        logic [2:0]     idx;
        logic [7:0]     shreg;
        logic           par;
        logic           line;
        logic           hi;
    } fsm_t;

    fsm_t q, n;
    logic [2:0] last_idx;
    logic       perr, is_brk;

    assign last_idx = 3'd4 + {1'b0, cfg_len};

    always_comb begin
        n        = q;
        push     = 1'b0;
        wr_entry = '0;
        perr     = par_en && ((^q.shreg ^ q.par) != par_odd);
        is_brk   = !rxd && (q.shreg == 8'h00) && !(par_en && q.par);
        unique case (q.st)
            S_IDLE: if (tick) begin
                n.line = rxd;
                if (q.line && !rxd) begin
                    n.st  = S_START;
                    n.cnt = '0;
                end
            end
            S_START: if (tick) begin
                if (q.cnt == CW'(CONFIRM - 1)) begin
                    if (rxd) begin
                        n.st   = S_IDLE;
                        n.line = 1'b1;
                    end else begin
                        n.st    = S_DATA;
                        n.cnt   = '0;
                        n.idx   = '0;
                        n.shreg = '0;
                        n.par   = 1'b0;
                    end
                end else begin
                    n.cnt = q.cnt + 1'b1;
                end
            end
            S_DATA: if (tick) begin
                if (q.cnt == CW'(OSR - 1)) begin
                    n.cnt            = '0;
                    n.shreg[q.idx]   = rxd;
                    if (q.idx == last_idx) n.st = par_en ? S_PAR : S_STOP;
                    else                   n.idx = q.idx + 1'b1;
                end else begin
                    n.cnt = q.cnt + 1'b1;
                end
            end
            S_PAR: if (tick) begin
                if (q.cnt == CW'(OSR - 1)) begin
                    n.cnt = '0;
                    n.par = rxd;
                    n.st  = S_STOP;
                end else begin
                    n.cnt = q.cnt + 1'b1;
                end
            end
            S_STOP: if (tick) begin
                if (q.cnt == CW'(OSR - 1)) begin
                    push             = 1'b1;
                    n.cnt            = '0;
                    wr_entry.data    = q.shreg;
                    wr_entry.par_err = perr && !is_brk;
                    wr_entry.frm_err = !rxd && !is_brk;
                    wr_entry.brk     = is_brk;
                    if (rxd) begin
                        n.st   = S_IDLE;
                        n.line = 1'b1;
                    end else if (is_brk) begin
                        n.st = S_BRK;
                        n.hi = 1'b0;
                    end else if (q.shreg != 8'h00) begin
                        n.st = S_HALF;
                    end else begin
                        n.st   = S_IDLE;
                        n.line = 1'b0;
                    end
                end else begin
                    n.cnt = q.cnt + 1'b1;
                end
            end
            S_HALF: if (tick) begin
                if (q.cnt == CW'(HALF - 1)) begin
                    n.cnt = '0;
                    if (!rxd) begin
                        n.st = S_START;
                    end else begin
                        n.st   = S_IDLE;
                        n.line = 1'b1;
                    end
                end else begin
                    n.cnt = q.cnt + 1'b1;
                end
            end
            S_BRK: begin
                if (rxd) begin
                    if (q.hi) begin
                        n.st   = S_IDLE;
                        n.line = 1'b1;
                        n.hi   = 1'b0;
                    end else begin
                        n.hi = 1'b1;
                    end
                end else begin
                    n.hi = 1'b0;
                end
            end
            default: n.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.line <= 1'b1;
        end else begin
            q <= n;
        end
    end

    // R9: leaving break needs two consecutive high samples
    p_brk_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st) == S_BRK && q.st != S_BRK) |-> ($past(rxd) && $past(rxd, 2)));

    // R3: five-bit characters carry zero upper bits
    p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && cfg_len == 2'd0) |-> (wr_entry.data[7:5] == 3'b000));

    // R1: a confirmation sample is only reached from an armed start
    p_start_from_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_DATA && $past(q.st) != S_DATA) |-> ($past(q.st) == S_START));
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
    import rx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  rx_entry_t wr,
    input  logic      pop,
    input  logic      clr,
    output rx_entry_t head,
    output logic      empty,
    output logic      full,
    output logic      ovr
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          ovr;
    } fifo_t;

    fifo_t     q, n;
    rx_entry_t mem [DEPTH];
    logic      do_wr, do_rd;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == CW'(DEPTH));
    assign head  = mem[q.rp];
    assign ovr   = q.ovr;

    always_comb begin
        n     = q;
        do_wr = push && !full;
        do_rd = pop && !empty;
        if (do_wr) n.wp = nxt(q.wp);
        if (do_rd) n.rp = nxt(q.rp);
        case ({do_wr, do_rd})
            2'b10:   n.cnt = q.cnt + 1'b1;
            2'b01:   n.cnt = q.cnt - 1'b1;
            default: n.cnt = q.cnt;
        endcase
        if (clr)          n.ovr = 1'b0;
        if (push && full) n.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[q.wp] <= wr;
    end

    p_full_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(q.cnt));

    p_ovr_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ovr && !clr) |=> q.ovr);

    p_ready_after_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> !empty);

    p_pop_dec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !push) |=> (q.cnt == $past(q.cnt) - CW'(1)));
endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
    import rx_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int OSR     = 16,
    parameter int CONFIRM = 8,
    parameter int SYNC    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       rd_en,
    input  logic       err_clr,
    output logic       rx_rdy,
    output logic [7:0] rd_data,
    output logic       rd_par_err,
    output logic       rd_frm_err,
    output logic       rd_brk,
    output logic       ovr_err
);
    logic      rxd_s;
    logic      push;
    rx_entry_t wr_entry, head;
    logic      empty, full;

    rx_sync #(.STAGES(SYNC)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rxd_s)
    );

    rx_frame_fsm #(.OSR(OSR), .CONFIRM(CONFIRM)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick16),
        .rxd     (rxd_s),
        .cfg_len (cfg_len),
        .par_en  (cfg_par_en),
        .par_odd (cfg_par_odd),
        .push    (push),
        .wr_entry(wr_entry)
    );

    rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (push),
        .wr   (wr_entry),
        .pop  (rd_en),
        .clr  (err_clr),
        .head (head),
        .empty(empty),
        .full (full),
        .ovr  (ovr_err)
    );

    assign rx_rdy     = !empty;
    assign rd_data    = head.data;
    assign rd_par_err = head.par_err;
    assign rd_frm_err = head.frm_err;
    assign rd_brk     = head.brk;

    // R8: a break entry at the head always reads as zero data
    p_brk_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rdy && rd_brk) |-> (rd_data == 8'h00 && !rd_frm_err && !rd_par_err));
endmodule

// File: tb/tb_rx_deframer.sv
module tb_rx_deframer;
    localparam int BITCLK = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       rd_en = 1'b0;
    logic       err_clr = 1'b0;
    logic       rx_rdy;
    logic [7:0] rd_data;
    logic       rd_par_err, rd_frm_err, rd_brk, ovr_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    rx_deframer dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .rd_en(rd_en), .err_clr(err_clr), .rx_rdy(rx_rdy), .rd_data(rd_data),
        .rd_par_err(rd_par_err), .rd_frm_err(rd_frm_err), .rd_brk(rd_brk),
        .ovr_err(ovr_err)
    );

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick16 = 1'b1;
            @(negedge clk);
            tick16 = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        rxd = b;
        repeat (BITCLK) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] d, input int nb, input bit flip_par,
                             input logic stop, input int gap);
        logic [7:0] m;
        logic p;
        m = d & ((8'h01 << nb) - 8'h01);
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) drive_bit(d[i]);
        if (cfg_par_en) begin
            p = (^m) ^ cfg_par_odd;
            if (flip_par) p = ~p;
            drive_bit(p);
        end
        drive_bit(stop);
        for (int g = 0; g < gap; g++) drive_bit(1'b1);
    endtask

    task automatic pop_check(input string tag, input logic [7:0] d, input logic pe,
                             input logic fe, input logic bk);
        @(negedge clk);
        chk({tag, " rdy"}, {31'd0, rx_rdy}, 32'd1);
        chk({tag, " data"}, {24'd0, rd_data}, {24'd0, d});
        chk({tag, " flags"}, {29'd0, rd_par_err, rd_frm_err, rd_brk}, {29'd0, pe, fe, bk});
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_cfg(input logic [1:0] len, input logic pen, input logic podd);
        cfg_len = len; cfg_par_en = pen; cfg_par_odd = podd;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R10 reset rdy", {31'd0, rx_rdy}, 32'd0);
        chk("R11 reset ovr", {31'd0, ovr_err}, 32'd0);
    endtask

    task automatic t_basic;
        set_cfg(2'd3, 1'b0, 1'b0);
        send_char(8'hA5, 8, 0, 1'b1, 0);
        send_char(8'h3C, 8, 0, 1'b1, 1);
        pop_check("R2 first 8N1", 8'hA5, 0, 0, 0);
        pop_check("R5 back-to-back", 8'h3C, 0, 0, 0);
        @(negedge clk);
        chk("R10 drained", {31'd0, rx_rdy}, 32'd0);
    endtask

    task automatic t_short;
        set_cfg(2'd0, 1'b0, 1'b0);
        send_char(8'hFF, 5, 0, 1'b1, 1);
        pop_check("R3 five bit", 8'h1F, 0, 0, 0);
        set_cfg(2'd1, 1'b0, 1'b0);
        send_char(8'hEA, 6, 0, 1'b1, 1);
        pop_check("R3 six bit", 8'h2A, 0, 0, 0);
        set_cfg(2'd3, 1'b0, 1'b0);
    endtask

    task automatic t_parity;
        set_cfg(2'd2, 1'b1, 1'b0);
        send_char(8'h35, 7, 0, 1'b1, 1);
        send_char(8'h35, 7, 1, 1'b1, 1);
        pop_check("R4 even good", 8'h35, 0, 0, 0);
        pop_check("R4 even bad", 8'h35, 1, 0, 0);
        set_cfg(2'd3, 1'b1, 1'b1);
        send_char(8'hC1, 8, 0, 1'b1, 1);
        send_char(8'hC1, 8, 1, 1'b1, 1);
        pop_check("R4 odd good", 8'hC1, 0, 0, 0);
        pop_check("R4 odd bad", 8'hC1, 1, 0, 0);
        set_cfg(2'd3, 1'b0, 1'b0);
    endtask

    task automatic t_reject;
        rxd = 1'b0;
        repeat (16) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BITCLK) @(negedge clk);
        chk("R1 glitch rejected", {31'd0, rx_rdy}, 32'd0);
        send_char(8'h96, 8, 0, 1'b1, 1);
        pop_check("R1 after reject", 8'h96, 0, 0, 0);
    endtask

    task automatic t_restart;
        send_char(8'h0F, 8, 0, 1'b0, 0);
        send_char(8'h81, 8, 0, 1'b1, 2);
        pop_check("R6 framing flag", 8'h0F, 0, 1, 0);
        pop_check("R7 restart char", 8'h81, 0, 0, 0);
        @(negedge clk);
        chk("R7 no extra entry", {31'd0, rx_rdy}, 32'd0);
    endtask

    task automatic t_break;
        rxd = 1'b0;
        repeat (12 * BITCLK) @(negedge clk);
        rxd = 1'b1;
        @(negedge clk);
        rxd = 1'b0;
        repeat (10 * BITCLK) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BITCLK) @(negedge clk);
        pop_check("R8 break entry", 8'h00, 0, 0, 1);
        @(negedge clk);
        chk("R9 one-clock high ignored", {31'd0, rx_rdy}, 32'd0);
        rxd = 1'b0;
        repeat (10 * BITCLK) @(negedge clk);
        rxd = 1'b1;
        repeat (2) @(negedge clk);
        rxd = 1'b0;
        repeat (10 * BITCLK) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BITCLK) @(negedge clk);
        pop_check("R9 first break", 8'h00, 0, 0, 1);
        pop_check("R9 break after two highs", 8'h00, 0, 0, 1);
        send_char(8'h5A, 8, 0, 1'b1, 1);
        pop_check("R9 normal after break", 8'h5A, 0, 0, 0);
    endtask

    task automatic t_empty_pop;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        chk("R10 empty pop ignored", {31'd0, rx_rdy}, 32'd0);
        send_char(8'h77, 8, 0, 1'b1, 1);
        pop_check("R10 after empty pop", 8'h77, 0, 0, 0);
        @(negedge clk);
        chk("R10 empty again", {31'd0, rx_rdy}, 32'd0);
    endtask

    task automatic t_overrun;
        for (int k = 1; k <= 4; k++) send_char(8'(k), 8, 0, 1'b1, 1);
        chk("R11 no ovr at full", {31'd0, ovr_err}, 32'd0);
        send_char(8'h05, 8, 0, 1'b1, 1);
        chk("R11 ovr set", {31'd0, ovr_err}, 32'd1);
        for (int k = 1; k <= 4; k++) pop_check("R11 order kept", 8'(k), 0, 0, 0);
        @(negedge clk);
        chk("R11 fifth dropped", {31'd0, rx_rdy}, 32'd0);
        chk("R11 ovr sticky", {31'd0, ovr_err}, 32'd1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        @(negedge clk);
        chk("R11 ovr cleared", {31'd0, ovr_err}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=running exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2 * BITCLK) @(negedge clk);
        t_basic();
        t_short();
        t_parity();
        t_reject();
        t_restart();
        t_break();
        t_empty_pop();
        t_overrun();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule